// File: doc/BRIEF.md
# Pairwise-Order LRU Replacement Unit

This unit tracks the age order of the ways in every set of a set-associative cache. Each set holds one small field of ordering bits. Each bit records which way of one pair of ways was used less recently. Every access to a way updates that field so the accessed way becomes the newest. When a miss is requested, the unit returns the oldest way of the indexed set as the victim one cycle later.

A second port lets software read and overwrite the ordering field of any set. Software must write only patterns that describe a total order of the ways. A write from software and a hardware update to the same set in the same cycle resolve in favour of software. With the default parameters the unit holds 4 ways and 256 sets, which gives 6 bits per set.

Top module: `lru_pairwise_repl`

## Requirements
- R1: After reset every set's field reads 6'b000000, which orders way 0 oldest through way 3 newest, so the victim of any set is way 0.
- R2: Bit positions 0 to 5 of a field belong to the way pairs (0,1), (0,2), (0,3), (1,2), (1,3), (2,3) in that order. A bit value of 0 means the lower-numbered way of the pair is older, and 1 means the higher-numbered way is older.
- R3: When acc_valid is high at a clock edge, the field of set_idx is rewritten so that acc_way is newer than each other way. The three bits of pairs that do not contain acc_way are unchanged.
- R4: When miss_req is high at a clock edge, victim_valid is high in the next cycle and victim_way is the way that every bit of set_idx's field marks as older than its partner. The field used is the one held before any update in that same cycle.
- R5: victim_valid is low in the cycle after an edge with miss_req low.
- R6: An access changes only the field of the set it names. Other sets keep their order.
- R7: When sw_wr_en is high at a clock edge, the field of sw_set takes the value sw_wdata.
- R8: When sw_rd_en is high at a clock edge, sw_rdata in the next cycle shows the field of sw_set as it was before that edge's updates. Otherwise sw_rdata holds its value.
- R9: If a software write and an access name the same set in one cycle, the set takes the software value.
- R10: A software write and an access to different sets in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_idx | input | 8 | Set used by access and miss |
| acc_valid | input | 1 | Access strobe |
| acc_way | input | 2 | Accessed way |
| miss_req | input | 1 | Request a victim for set_idx |
| victim_valid | output | 1 | Victim result valid |
| victim_way | output | 2 | Oldest way of the requested set |
| sw_set | input | 8 | Set addressed by software |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wdata | input | 6 | Ordering field to write |
| sw_rd_en | input | 1 | Software read strobe |
| sw_rdata | output | 6 | Ordering field read back |

## Verification
The bench walks a single set through a series of accesses chosen so that the victim moves to every way. A design that set a pair bit in the wrong direction, or that cleared bits outside the accessed way's pairs, would return the wrong victim or read back the wrong field. Directed cases put a miss, an access and software traffic into one cycle. These cases expose a victim taken after the update instead of before it, a hardware update that overrides a software write to the same set, and a software write that blocks an access to a different set. Separate checks show that other sets keep their order, that sw_rdata holds between reads, and that reset restores all-zero fields.

// File: rtl/lru_pkg.sv
package lru_pkg;

   // Bit position of the ordering bit for the pair (lo, hi), lo < hi.
   // Pairs are numbered by lo first, then by hi.
   function automatic int pair_index(input int lo, input int hi, input int ways);
      return lo * ways - (lo * (lo + 1)) / 2 + (hi - lo - 1);
   endfunction

   function automatic int pair_count(input int ways);
      return (ways * (ways - 1)) / 2;
   endfunction

endpackage

// File: rtl/lru_age_update.sv
module lru_age_update
   import lru_pkg::*;
#(
   parameter int WAYS  = 4,
   parameter int PAIRS = pair_count(WAYS),
   parameter int WAY_W = $clog2(WAYS)
) (
   input  logic [PAIRS-1:0] cur_order,
   input  logic [WAY_W-1:0] touched_way,
   output logic [PAIRS-1:0] next_order
);

   // Each pair bit follows the touched way: if the touched way is the
   // lower one, the higher becomes older (1); if it is the higher, the
   // lower becomes older (0); otherwise the bit is kept.
   for (genvar lo = 0; lo < WAYS; lo++) begin : g_lo
      for (genvar hi = lo + 1; hi < WAYS; hi++) begin : g_hi
         localparam int P = pair_index(lo, hi, WAYS);
         assign next_order[P] = (touched_way == WAY_W'(lo)) ? 1'b1 :
                                (touched_way == WAY_W'(hi)) ? 1'b0 :
                                cur_order[P];
      end
   end

endmodule

// File: rtl/lru_victim_pick.sv
module lru_victim_pick
   import lru_pkg::*;
#(
   parameter int WAYS  = 4,
   parameter int PAIRS = pair_count(WAYS),
   parameter int WAY_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PAIRS-1:0] order,
   output logic [WAYS-1:0]  oldest_hot,
   output logic [WAY_W-1:0] oldest_way
);

   for (genvar v = 0; v < WAYS; v++) begin : g_way
      logic older_than_all;
      always_comb begin
         older_than_all = 1'b1;
         for (int k = 0; k < WAYS; k++) begin
            if (k < v) begin
               if (!order[pair_index(k, v, WAYS)]) older_than_all = 1'b0;
            end else if (k > v) begin
               if (order[pair_index(v, k, WAYS)]) older_than_all = 1'b0;
            end
         end
      end
      assign oldest_hot[v] = older_than_all;
   end

   always_comb begin
      oldest_way = '0;
      for (int v = 0; v < WAYS; v++) begin
         if (oldest_hot[v]) oldest_way = oldest_way | WAY_W'(v);
      end
   end

   // R2: a legal field always names exactly one oldest way
   assert_one_oldest_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(oldest_hot));

endmodule

// File: rtl/lru_state_store.sv
module lru_state_store #(
   parameter int NUM_SETS = 256,
   parameter int PAIRS    = 6,
   parameter int IDX_W    = $clog2(NUM_SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hw_we,
   input  logic [IDX_W-1:0] hw_set,
   input  logic [PAIRS-1:0] hw_data,
   input  logic             sw_we,
   input  logic [IDX_W-1:0] sw_set,
   input  logic [PAIRS-1:0] sw_data,
   input  logic [IDX_W-1:0] rd_set_a,
   output logic [PAIRS-1:0] rd_a,
   input  logic [IDX_W-1:0] rd_set_b,
   output logic [PAIRS-1:0] rd_b
);

   logic [PAIRS-1:0] fields [NUM_SETS];

   // Software write comes last, so it wins on a shared set.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < NUM_SETS; e++) fields[e] <= '0;
      end else begin
         if (hw_we) fields[hw_set] <= hw_data;
         if (sw_we) fields[sw_set] <= sw_data;
      end
   end

   assign rd_a = fields[rd_set_a];
   assign rd_b = fields[rd_set_b];

   // R9: software value survives a same-set hardware update
   assert_sw_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_we && hw_we && sw_set == hw_set) |=> fields[$past(sw_set)] == $past(sw_data));

   // R10: different-set hardware update still lands
   assert_hw_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_we && !(sw_we && sw_set == hw_set)) |=> fields[$past(hw_set)] == $past(hw_data));

endmodule

// File: rtl/lru_pairwise_repl.sv
module lru_pairwise_repl
   import lru_pkg::*;
#(
   parameter int WAYS     = 4,
   parameter int NUM_SETS = 256,
   parameter int PAIRS    = pair_count(WAYS),
   parameter int WAY_W    = $clog2(WAYS),
   parameter int IDX_W    = $clog2(NUM_SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] set_idx,
   input  logic             acc_valid,
   input  logic [WAY_W-1:0] acc_way,
   input  logic             miss_req,
   output logic             victim_valid,
   output logic [WAY_W-1:0] victim_way,
   input  logic [IDX_W-1:0] sw_set,
   input  logic             sw_wr_en,
   input  logic [PAIRS-1:0] sw_wdata,
   input  logic             sw_rd_en,
   output logic [PAIRS-1:0] sw_rdata
);

   if (WAYS < 2) begin : g_bad_ways
      $error("lru_pairwise_repl: WAYS must be at least 2");
   end
   if ((1 << WAY_W) != WAYS) begin : g_bad_pow_ways
      $error("lru_pairwise_repl: WAYS must be a power of two");
   end
   if ((1 << IDX_W) != NUM_SETS) begin : g_bad_sets
      $error("lru_pairwise_repl: NUM_SETS must be a power of two");
   end

   logic [PAIRS-1:0] cur_order;
   logic [PAIRS-1:0] upd_order;
   logic [PAIRS-1:0] sw_view;
   logic [WAYS-1:0]  cur_hot;
   logic [WAY_W-1:0] cur_oldest;
   logic [WAYS-1:0]  upd_hot;
   logic [WAY_W-1:0] upd_oldest;

   lru_state_store #(.NUM_SETS(NUM_SETS), .PAIRS(PAIRS), .IDX_W(IDX_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .hw_we    (acc_valid),
      .hw_set   (set_idx),
      .hw_data  (upd_order),
      .sw_we    (sw_wr_en),
      .sw_set   (sw_set),
      .sw_data  (sw_wdata),
      .rd_set_a (set_idx),
      .rd_a     (cur_order),
      .rd_set_b (sw_set),
      .rd_b     (sw_view)
   );

   lru_age_update #(.WAYS(WAYS), .PAIRS(PAIRS), .WAY_W(WAY_W)) u_update (
      .cur_order   (cur_order),
      .touched_way (acc_way),
      .next_order  (upd_order)
   );

   lru_victim_pick #(.WAYS(WAYS), .PAIRS(PAIRS), .WAY_W(WAY_W)) u_pick_cur (
      .clk        (clk),
      .rst_n      (rst_n),
      .order      (cur_order),
      .oldest_hot (cur_hot),
      .oldest_way (cur_oldest)
   );

   lru_victim_pick #(.WAYS(WAYS), .PAIRS(PAIRS), .WAY_W(WAY_W)) u_pick_upd (
      .clk        (clk),
      .rst_n      (rst_n),
      .order      (upd_order),
      .oldest_hot (upd_hot),
      .oldest_way (upd_oldest)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         victim_valid <= 1'b0;
         victim_way   <= '0;
         sw_rdata     <= '0;
      end else begin
         victim_valid <= miss_req;
         if (miss_req) victim_way <= cur_oldest;
         if (sw_rd_en) sw_rdata <= sw_view;
      end
   end

   // R3: the just-touched way can never be the oldest afterwards
   assert_touched_not_oldest_R3: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |-> upd_oldest != acc_way);

   // R4: a miss yields a valid victim on the next cycle
   assert_victim_follows_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
      miss_req |=> victim_valid);

   // R5: no miss, no victim
   assert_victim_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !miss_req |=> !victim_valid);

   // R8: read-back holds without a read strobe
   assert_rdata_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_rd_en |=> $stable(sw_rdata));

   // upd_hot is only used by the checker in u_pick_upd and the property above
   logic unused_hot;
   assign unused_hot = ^{upd_hot, cur_hot};

endmodule

// File: tb/test_lru_pairwise_repl.sv
`timescale 1ns/1ps
module test_lru_pairwise_repl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] set_idx = '0;
   logic       acc_valid = 1'b0;
   logic [1:0] acc_way = '0;
   logic       miss_req = 1'b0;
   logic       victim_valid;
   logic [1:0] victim_way;
   logic [7:0] sw_set = '0;
   logic       sw_wr_en = 1'b0;
   logic [5:0] sw_wdata = '0;
   logic       sw_rd_en = 1'b0;
   logic [5:0] sw_rdata;

   int n_checks = 0;
   int n_err = 0;
   logic [5:0] model [256];

   always #2.5 clk = ~clk;

   lru_pairwise_repl i_lru_pairwise_repl (
      .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .acc_valid(acc_valid),
      .acc_way(acc_way), .miss_req(miss_req), .victim_valid(victim_valid),
      .victim_way(victim_way), .sw_set(sw_set), .sw_wr_en(sw_wr_en),
      .sw_wdata(sw_wdata), .sw_rd_en(sw_rd_en), .sw_rdata(sw_rdata)
   );

   // pair (a,b), a<b, bit position per R2
   function automatic int pbit(int a, int b);
      case ({a[1:0], b[1:0]})
         4'b0001: return 0;
         4'b0010: return 1;
         4'b0011: return 2;
         4'b0110: return 3;
         4'b0111: return 4;
         default: return 5;
      endcase
   endfunction

   function automatic logic [5:0] touch(logic [5:0] s, int w);
      logic [5:0] r = s;
      for (int k = 0; k < 4; k++) begin
         if (k < w) r[pbit(k, w)] = 1'b0;
         else if (k > w) r[pbit(w, k)] = 1'b1;
      end
      return r;
   endfunction

   localparam logic [11:0] VEC [8] = '{
      {8'd5, 2'd0, 2'd1}, {8'd5, 2'd1, 2'd2}, {8'd5, 2'd2, 2'd3}, {8'd5, 2'd0, 2'd3},
      {8'd5, 2'd3, 2'd1}, {8'd5, 2'd1, 2'd2}, {8'd5, 2'd2, 2'd0}, {8'd5, 2'd0, 2'd3}
   };

   task automatic check(string req, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic access(int s, int w);
      @(negedge clk);
      set_idx = 8'(s); acc_way = 2'(w); acc_valid = 1'b1;
      @(negedge clk);
      acc_valid = 1'b0;
      model[s] = touch(model[s], w);
   endtask

   task automatic miss_check(string req, int s, int exp);
      @(negedge clk);
      set_idx = 8'(s); miss_req = 1'b1;
      @(negedge clk);
      miss_req = 1'b0;
      check({req, " victim_valid"}, int'(victim_valid), 1);
      check({req, " victim_way"}, int'(victim_way), exp);
   endtask

   task automatic sw_read(string req, int s, int exp);
      @(negedge clk);
      sw_set = 8'(s); sw_rd_en = 1'b1;
      @(negedge clk);
      sw_rd_en = 1'b0;
      check(req, int'(sw_rdata), exp);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++; n_err++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      for (int e = 0; e < 256; e++) model[e] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check("R1 victim_valid after reset", int'(victim_valid), 0);
      sw_read("R1 set 0 field", 0, 0);
      sw_read("R1 set 255 field", 255, 0);
      miss_check("R1 reset victim", 77, 0);

      // R5: idle cycle drops victim_valid
      @(negedge clk);
      check("R5 victim_valid idle", int'(victim_valid), 0);

      // R2/R3/R4 vector walk on set 5
      for (int i = 0; i < 8; i++) begin
         access(int'(VEC[i][11:4]), int'(VEC[i][3:2]));
         miss_check("R4 walk", int'(VEC[i][11:4]), int'(VEC[i][1:0]));
         sw_read("R2 R3 walk field", int'(VEC[i][11:4]), int'(model[VEC[i][11:4]]));
      end

      // R6: neighbour sets untouched
      sw_read("R6 set 4 untouched", 4, 0);
      miss_check("R6 set 6 victim", 6, 0);

      // R7: software write of a legal order 3,2,0,1 -> victim 3
      @(negedge clk);
      sw_set = 8'd20; sw_wdata = 6'b111110; sw_wr_en = 1'b1;
      @(negedge clk);
      sw_wr_en = 1'b0; model[20] = 6'b111110;
      sw_read("R7 written field", 20, 6'b111110);
      miss_check("R7 victim after write", 20, 3);

      // R8: read-back holds without strobe
      @(negedge clk);
      check("R8 rdata holds", int'(sw_rdata), 6'b111110);

      // R4 + R9: miss, access and software write on set 9 in one cycle
      @(negedge clk);
      set_idx = 8'd9; acc_way = 2'd3; acc_valid = 1'b1; miss_req = 1'b1;
      sw_set = 8'd9; sw_wdata = 6'b111111; sw_wr_en = 1'b1;
      @(negedge clk);
      acc_valid = 1'b0; miss_req = 1'b0; sw_wr_en = 1'b0;
      check("R4 pre-update victim", int'(victim_way), 0);
      model[9] = 6'b111111;
      sw_read("R9 software wins", 9, 6'b111111);
      miss_check("R9 victim after collision", 9, 3);

      // R10: access set 10 and write set 11 together
      @(negedge clk);
      set_idx = 8'd10; acc_way = 2'd0; acc_valid = 1'b1;
      sw_set = 8'd11; sw_wdata = 6'b111110; sw_wr_en = 1'b1;
      @(negedge clk);
      acc_valid = 1'b0; sw_wr_en = 1'b0;
      model[10] = touch(model[10], 0);
      sw_read("R10 access applied", 10, int'(model[10]));
      sw_read("R10 write applied", 11, 6'b111110);

      // R8: read same cycle as access returns the old field
      @(negedge clk);
      set_idx = 8'd12; acc_way = 2'd2; acc_valid = 1'b1;
      sw_set = 8'd12; sw_rd_en = 1'b1;
      @(negedge clk);
      acc_valid = 1'b0; sw_rd_en = 1'b0;
      check("R8 read before update", int'(sw_rdata), 0);
      model[12] = touch(model[12], 2);
      sw_read("R8 read after update", 12, int'(model[12]));

      // R1: reset mid-run clears everything
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      check("R1 victim_valid after second reset", int'(victim_valid), 0);
      sw_read("R1 set 5 cleared", 5, 0);
      miss_check("R1 set 20 victim cleared", 20, 0);

      finish_run();
   end

endmodule